// File: doc/BRIEF.md
# Control-Track Duty Mark Detector and Recorder

This block works on the control track of a tape transport. In detect mode it measures each playback control pulse. It counts the high time and the full rising-edge-to-rising-edge period in timebase ticks. When the high part is at least two thirds of the period, it treats the pulse as a mark. It then clears a software-visible duty flag and raises a one-clock interrupt request.

In record mode it produces a continuous train of record control pulses with a fixed period, counted in ticks. The high time of each pulse normally comes from a programmable duty input. Software requests a mark pulse by writing 0 to the duty flag. The next pulse that starts then uses a fixed mark high time of at least two thirds of the period. When that pulse ends, the flag returns to 1 by itself. Every completed record pulse raises one interrupt.

All counting advances only on cycles where the timebase enable is high. Outputs are registered, and reset is synchronous and active high.

Top module: `ctl_mark_unit`

## Requirements
- R1: During and after reset, `rec_ctl` is 0, `irq` is 0 and `duty_flag` is 1.
- R2: In detect mode (`mode` = 2'b01), a completed playback period with 3×high ≥ 2×period, both counted in ticks from one rising edge of `pb_ctl` to the next, clears `duty_flag` to 0.
- R3: Each detected mark raises `irq` for exactly one clock cycle.
- R4: A playback period with 3×high < 2×period neither clears `duty_flag` nor raises `irq`.
- R5: The first rising edge after entering detect mode only starts a measurement and can never produce a mark by itself.
- R6: When the period counter (`CNT_W` bits) saturates before the next rising edge, that measurement is discarded with no mark, and measurement resumes from that edge.
- R7: Switching `mode` into detect sets `duty_flag` to 1.
- R8: In record mode (`mode` = 2'b10) with `duty_flag` = 1 at period start, `rec_ctl` repeats every `REC_PERIOD` ticks and is high for `duty_val` ticks at the start of each period.
- R9: A record period that starts with `duty_flag` = 0 is high for the mark length ceil-style (2×`REC_PERIOD`+2)/3 ticks (11 of 16 by default), and `duty_flag` returns to 1 at the end of that period.
- R10: In record mode `irq` pulses once per completed record period.
- R11: The high length is fixed at the start of each record period, so a flag write during a pulse does not change that pulse and takes effect with the next period.
- R12: A write on `flag_wr` loads `flag_wdata` into `duty_flag` on the next cycle and takes priority over every automatic flag update.
- R13: Record timing advances only on `tick` cycles, and `rec_ctl` stays 0 outside record mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; all measurement and generation counts advance on it |
| mode | input | 2 | 2'b00 idle, 2'b01 detect, 2'b10 record, 2'b11 idle |
| pb_ctl | input | 1 | Playback control pulse |
| duty_val | input | DUTY_W | Record high time in ticks for normal pulses |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Value written to the flag |
| rec_ctl | output | 1 | Generated record control pulse |
| duty_flag | output | 1 | Duty flag (0 = mark detected / mark requested) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A wrong high or period count in the meter shows up at the threshold boundary. A period at exactly two thirds is then missed, or one a single tick short of it is flagged, and the error appears on `irq` and `duty_flag` within three clocks of the closing edge. A stale arm or overflow state produces a mark that should not exist on the first evaluated edge after a mode entry or a long pulse. In the generator, a wrong phase or latched length changes the measured high and low spans of `rec_ctl` within one record period. A mistimed flag restore shows as two mark pulses in a row, or as none, on the pulse right after a request.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_DET  = 2'b01,
    MODE_REC  = 2'b10,
    MODE_RSV  = 2'b11
  } ctl_mode_e;
endpackage

// File: rtl/ctl_duty_meter.sv
module ctl_duty_meter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic pb,
  output logic mark_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             pb_q, pb_d;
  logic [CNT_W-1:0] hi_cnt, per_cnt;
  logic             armed, ovf, mark_q;
  logic             rise;
  logic [CNT_W+1:0] hi_x3, per_x2;
  logic             is_mark;

  assign rise    = pb_q & ~pb_d;
  assign hi_x3   = {2'b00, hi_cnt} + {1'b0, hi_cnt, 1'b0};
  assign per_x2  = {1'b0, per_cnt, 1'b0};
  assign is_mark = (per_cnt != '0) && (hi_x3 >= per_x2);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pb_q    <= 1'b0;
      pb_d    <= 1'b0;
      hi_cnt  <= '0;
      per_cnt <= '0;
      armed   <= 1'b0;
      ovf     <= 1'b0;
      mark_q  <= 1'b0;
    end else begin
      pb_q   <= pb;
      pb_d   <= pb_q;
      mark_q <= 1'b0;
      if (rise) begin
        mark_q  <= armed && !ovf && is_mark;
        armed   <= 1'b1;
        ovf     <= 1'b0;
        per_cnt <= CNT_W'(tick);
        hi_cnt  <= CNT_W'(tick);
      end else if (tick) begin
        if (per_cnt == CNT_MAX) ovf <= 1'b1;
        else                    per_cnt <= per_cnt + 1'b1;
        if (pb_q && hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  assign mark_o = mark_q;

  // R5
  first_edge_chk: assert property (@(posedge clk) disable iff (rst || !en)
    (rise && !armed) |=> !mark_q);
  // R6
  ovf_discard_chk: assert property (@(posedge clk) disable iff (rst || !en)
    (rise && ovf) |=> !mark_q);
endmodule

// File: rtl/ctl_rec_gen.sv
module ctl_rec_gen #(
  parameter int REC_PERIOD = 16,
  parameter int DUTY_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [DUTY_W-1:0] duty,
  input  logic              use_mark,
  output logic              rec_o,
  output logic              run_o,
  output logic              wrap_o,
  output logic              cur_mark_o
);
  localparam int PH_W      = (REC_PERIOD > 2) ? $clog2(REC_PERIOD) : 1;
  localparam int MARK_HIGH = (2 * REC_PERIOD + 2) / 3;
  localparam int CMP_W     = (DUTY_W > PH_W) ? DUTY_W : PH_W;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(REC_PERIOD - 1);

  logic [PH_W-1:0]   phase;
  logic [DUTY_W-1:0] len, next_len;
  logic              run, mark_q, rec_q;
  logic [CMP_W-1:0]  phase_x, len_x;

  assign next_len = use_mark ? DUTY_W'(MARK_HIGH) : duty;
  assign phase_x  = CMP_W'(phase);
  assign len_x    = CMP_W'(len);
  assign wrap_o   = run && tick && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run    <= 1'b0;
      phase  <= '0;
      len    <= '0;
      mark_q <= 1'b0;
      rec_q  <= 1'b0;
    end else begin
      rec_q <= run && (phase_x < len_x);
      if (!run) begin
        run    <= 1'b1;
        phase  <= '0;
        len    <= next_len;
        mark_q <= use_mark;
      end else if (tick) begin
        if (phase == PH_LAST) begin
          phase  <= '0;
          len    <= next_len;
          mark_q <= use_mark;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  assign rec_o      = rec_q;
  assign run_o      = run;
  assign cur_mark_o = mark_q;

  // R13
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst || !en)
    (run && !tick) |=> $stable(phase));
endmodule

// File: rtl/ctl_mark_unit.sv
module ctl_mark_unit #(
  parameter int CNT_W      = 8,
  parameter int REC_PERIOD = 16,
  parameter int DUTY_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              pb_ctl,
  input  logic [DUTY_W-1:0] duty_val,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  output logic              rec_ctl,
  output logic              duty_flag,
  output logic              irq
);
  import ctl_pkg::*;

  ctl_mode_e mode_e, mode_prev;
  logic      det_en, rec_en, enter_det;
  logic      det_mark;
  logic      gen_run, gen_wrap, gen_cur_mark, gen_rec;
  logic      flag_q, flag_nx, irq_q;

  assign mode_e    = ctl_mode_e'(mode);
  assign det_en    = (mode_e == MODE_DET);
  assign rec_en    = (mode_e == MODE_REC);
  assign enter_det = det_en && (mode_prev != MODE_DET);

  ctl_duty_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .en(det_en), .tick(tick), .pb(pb_ctl),
    .mark_o(det_mark)
  );

  ctl_rec_gen #(.REC_PERIOD(REC_PERIOD), .DUTY_W(DUTY_W)) u_gen (
    .clk(clk), .rst(rst), .en(rec_en), .tick(tick), .duty(duty_val),
    .use_mark(~flag_nx), .rec_o(gen_rec), .run_o(gen_run),
    .wrap_o(gen_wrap), .cur_mark_o(gen_cur_mark)
  );

  always_comb begin
    flag_nx = flag_q;
    if (flag_wr)                      flag_nx = flag_wdata;
    else if (gen_wrap && gen_cur_mark) flag_nx = 1'b1;
    else if (det_mark)                flag_nx = 1'b0;
    else if (enter_det)               flag_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b1;
      irq_q     <= 1'b0;
      mode_prev <= MODE_IDLE;
    end else begin
      flag_q    <= flag_nx;
      irq_q     <= det_mark | gen_wrap;
      mode_prev <= mode_e;
    end
  end

  assign rec_ctl   = gen_rec;
  assign duty_flag = flag_q;
  assign irq       = irq_q;

  // R12
  flag_write_chk: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (duty_flag == $past(flag_wdata)));
  // R2
  mark_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (det_mark && !flag_wr) |=> (!duty_flag && irq));
  // R9
  mark_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_wrap && gen_cur_mark && !flag_wr) |=> duty_flag);
  // R3
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R13
  rec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_run |=> !rec_ctl);
endmodule

// File: tb/ctl_mark_unit_bench.sv
module ctl_mark_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       pb_ctl = 1'b0;
  logic [7:0] duty_val = 8'd6;
  logic       flag_wr = 1'b0;
  logic       flag_wdata = 1'b0;
  logic       rec_ctl, duty_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  logic tick_half = 1'b0;

  always #4 clk = ~clk;

  ctl_mark_unit u_ctl_mark_unit (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .pb_ctl(pb_ctl),
    .duty_val(duty_val), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .rec_ctl(rec_ctl), .duty_flag(duty_flag), .irq(irq)
  );

  always @(negedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

  initial forever begin
    @(negedge clk);
    if (tick_half) tick = ~tick;
    else           tick = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_flag(input logic v);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk); flag_wr = 1'b0;
  endtask

  task automatic det_restart();
    pb_ctl = 1'b0; mode = 2'b00; cyc(3);
    mode = 2'b01; cyc(3);
  endtask

  // k full periods of h high / l low ticks, then one more rising edge
  task automatic pattern(input int h, input int l, input int k);
    irq_cnt = 0;
    for (int i = 0; i < k; i++) begin
      pb_ctl = 1'b1; cyc(h);
      pb_ctl = 1'b0; cyc(l);
    end
    pb_ctl = 1'b1; cyc(2);
    pb_ctl = 1'b0; cyc(6);
  endtask

  // waits for rec_ctl high, counts high cycles; writes flag 0 at count wr_at
  task automatic meas_high(input int wr_at, output int hi);
    int guard = 0;
    hi = 0;
    while (rec_ctl !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
    while (rec_ctl === 1'b1 && hi < 1000) begin
      if (hi == wr_at) begin flag_wr = 1'b1; flag_wdata = 1'b0; end
      else flag_wr = 1'b0;
      hi++;
      @(negedge clk);
    end
    flag_wr = 1'b0;
  endtask

  task automatic meas_low(output int lo);
    lo = 0;
    while (rec_ctl === 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 rec_ctl", rec_ctl, 0);
    chk("R1 irq", irq, 0);
    chk("R1 duty_flag", duty_flag, 1);
  endtask

  task automatic t_detect();
    mode = 2'b00; wr_flag(1'b0);
    det_restart();
    chk("R7 flag set on detect entry", duty_flag, 1);
    pattern(20, 10, 3);
    chk("R2 boundary 2/3 marks", irq_cnt, 3);
    chk("R2 flag cleared", duty_flag, 0);
    det_restart();
    pattern(19, 10, 3);
    chk("R4 just under threshold irq", irq_cnt, 0);
    chk("R4 flag kept", duty_flag, 1);
    det_restart();
    pattern(40, 5, 2);
    chk("R3 one irq cycle per mark", irq_cnt, 2);
    det_restart();
    pattern(10, 20, 2);
    chk("R4 low duty", irq_cnt, 0);
    det_restart();
    pattern(30, 5, 0);
    chk("R5 first edge only arms", irq_cnt, 0);
    chk("R5 flag", duty_flag, 1);
    det_restart();
    pattern(300, 10, 1);
    chk("R6 overflow discarded", irq_cnt, 0);
    pattern(20, 10, 2);
    chk("R6 resumes after overflow", irq_cnt, 2);
  endtask

  task automatic t_record();
    int hi, lo;
    mode = 2'b00; duty_val = 8'd6; cyc(2);
    wr_flag(1'b0);
    mode = 2'b10;
    meas_high(-1, hi);
    chk("R9 mark high length", hi, 11);
    chk("R9 flag held during mark period", duty_flag, 0);
    meas_low(lo);
    chk("R8 period after mark", hi + lo, 16);
    chk("R9 flag restored", duty_flag, 1);
    meas_high(-1, hi);
    chk("R8 normal high length", hi, 6);
    meas_low(lo);
    chk("R8 normal low length", lo, 10);
    meas_high(2, hi);
    chk("R11 write mid pulse ignored", hi, 6);
    chk("R12 flag written", duty_flag, 0);
    meas_high(-1, hi);
    chk("R11 write applies next period", hi, 11);
    meas_high(-1, hi);
    chk("R9 single mark per request", hi, 6);
    irq_cnt = 0; cyc(48);
    chk("R10 irq per period", irq_cnt, 3);
    tick_half = 1'b1;
    meas_high(-1, hi);
    meas_high(-1, hi);
    meas_low(lo);
    chk("R13 half-rate high", hi, 12);
    chk("R13 half-rate low", lo, 20);
    tick_half = 1'b0;
    mode = 2'b00; cyc(3);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      if (rec_ctl) hi++;
      @(negedge clk);
    end
    chk("R13 no output outside record", hi, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(4);
    t_reset();
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_detect();
    t_record();
    finish_run();
  end
endmodule